// File: doc/BRIEF.md
# Multi-Format Serial Audio Input Receiver

This block receives a three-wire stereo serial audio stream (bit clock, word-select clock and serial data) as a slave to externally supplied clocks and turns it into parallel 24-bit left and right samples. All three serial inputs pass through a two-stage synchronizer into the system clock domain. Data and word select are captured on each bit-clock rising edge seen there. A word-select transition marks the end of one half-frame and the start of the next.

A 3-bit format code selects the framing. The choices are MSB-first data aligned to the word-select edge, the same data delayed by one bit clock with inverted channel polarity, or data aligned to the LSB at the end of each half-frame at 16, 18, 20 or 24 bits. Narrow right-aligned samples are sign-extended to 24 bits. A single-cycle valid strobe marks a completed left/right pair. A new code is adopted only at a frame boundary. The two unused codes produce zero samples and raise an error flag.

Top module: `audio_serial_rx`

## Requirements
- R1: After reset, left_o and right_o are zero, valid_o and fmt_err_o are low, and the active format is code 000.
- R2: Code 000 (left-justified): the bit captured on the first bit-clock rising edge after a word-select transition is the sample MSB, and word select high marks the left channel. The first 24 bits of a half-frame are kept, later bits are ignored, and a half-frame shorter than 24 bits leaves the missing low bits zero.
- R3: Code 001 (I2S): the MSB is the bit captured one bit clock after the word-select transition, and the bits that follow fill the sample. Word select low marks the left channel.
- R4: Right-justified codes keep the last N bits before the word-select transition that ends the half-frame: 010 gives N=16, 011 gives N=24, 100 gives N=20 and 101 gives N=18. Word select high marks the left channel.
- R5: Right-justified samples narrower than 24 bits are sign-extended from their bit N-1 to 24 bits.
- R6: valid_o is a one-cycle pulse raised when a right half-frame that followed a left half-frame ends. left_o and right_o change only in that cycle and hold their values otherwise.
- R7: Codes 110 and 111 are reserved. While one is active, fmt_err_o is high and every pair delivered carries zero samples.
- R8: A change on fmt_i takes effect only at a frame boundary, which is the word-select transition that ends a right half-frame. fmt_err_o follows the active format, not the input.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sck_i | input | 1 | Serial bit clock, data captured on its rising edge |
| lrck_i | input | 1 | Word-select clock, separates the channel half-frames |
| sdata_i | input | 1 | Serial audio data |
| fmt_i | input | 3 | Framing format code |
| left_o | output | 24 | Left channel sample, sign-extended |
| right_o | output | 24 | Right channel sample, sign-extended |
| valid_o | output | 1 | One-cycle strobe when a new stereo pair is presented |
| fmt_err_o | output | 1 | High while a reserved format code is active |

## Verification
The assertions check on every cycle that the valid strobe never lasts more than one cycle and that the sample outputs never move without it. They also check that every pair decoded under a reserved code is zero, and that every pair decoded under a narrow right-justified code is sign-extended. Correct bit placement for each framing, channel polarity, the dropping of bits beyond 24, and the deferral of a format change to the next frame boundary depend on the serial waveform. Only the bench's directed scenarios can show these, by comparing each delivered pair with a sample computed from the transmitted bits.

// File: rtl/audio_serial_rx.sv
module audio_serial_rx #(
  parameter int CW = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sck_i,
  input  logic        lrck_i,
  input  logic        sdata_i,
  input  logic [2:0]  fmt_i,
  output logic [23:0] left_o,
  output logic [23:0] right_o,
  output logic        valid_o,
  output logic        fmt_err_o
);

  localparam logic [CW-1:0] CNT_MAX = {CW{1'b1}};
  localparam logic [CW-1:0] WORD    = CW'(24);
  localparam logic [2:0]    F_I2S   = 3'b001;

  function automatic logic [23:0] decode(input logic [2:0] f, input logic [23:0] c,
                                         input logic [23:0] s);
    case (f)
      3'b000, 3'b001: return c;
      3'b010:         return {{8{s[15]}}, s[15:0]};
      3'b011:         return s;
      3'b100:         return {{4{s[19]}}, s[19:0]};
      3'b101:         return {{6{s[17]}}, s[17:0]};
      default:        return '0;
    endcase
  endfunction

  logic [2:0]    sck_s;
  logic [1:0]    ws_s, sd_s;
  logic          primed, started, ws_q, have_left;
  logic [CW-1:0] cnt;
  logic [23:0]   cap, sh, left_hold;
  logic [2:0]    fmt_act;

  wire           rise      = sck_s[1] & ~sck_s[2];
  wire           ws        = ws_s[1];
  wire           sd        = sd_s[1];
  wire           trans     = rise && primed && (ws != ws_q);
  wire           half_left = (fmt_act == F_I2S) ? ~ws_q : ws_q;
  wire           done      = trans && started;
  wire           load      = trans && (!started || !half_left);
  wire [2:0]     fmt_nxt   = load ? fmt_i : fmt_act;
  wire [CW-1:0]  k         = (cnt == CNT_MAX) ? cnt : cnt + 1'b1;
  wire [CW-1:0]  off       = (fmt_act == F_I2S) ? CW'(1) : CW'(0);
  wire [CW-1:0]  rel       = k - off;
  wire           wr        = (k >= off) && (rel < WORD);
  wire [4:0]     pos       = 5'd23 - rel[4:0];
  wire [23:0]    dec       = decode(fmt_act, cap, sh);

  assign fmt_err_o = fmt_act[2] & fmt_act[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sck_s <= '0;
      ws_s  <= '0;
      sd_s  <= '0;
    end else begin
      sck_s <= {sck_s[1:0], sck_i};
      ws_s  <= {ws_s[0], lrck_i};
      sd_s  <= {sd_s[0], sdata_i};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      primed    <= 1'b0;
      started   <= 1'b0;
      ws_q      <= 1'b0;
      have_left <= 1'b0;
      cnt       <= '0;
      cap       <= '0;
      sh        <= '0;
      left_hold <= '0;
      fmt_act   <= 3'b000;
      left_o    <= '0;
      right_o   <= '0;
      valid_o   <= 1'b0;
    end else begin
      valid_o <= 1'b0;
      if (rise) begin
        primed <= 1'b1;
        ws_q   <= ws;
        sh     <= {sh[22:0], sd};
        if (trans) begin
          started <= 1'b1;
          fmt_act <= fmt_nxt;
          cnt     <= '0;
          cap     <= (fmt_nxt == F_I2S) ? 24'd0 : {sd, 23'd0};
          if (done) begin
            if (half_left) begin
              left_hold <= dec;
              have_left <= 1'b1;
            end else begin
              if (have_left) begin
                left_o  <= left_hold;
                right_o <= dec;
                valid_o <= 1'b1;
              end
              have_left <= 1'b0;
            end
          end
        end else begin
          cnt <= k;
          if (wr) cap[pos] <= sd;
        end
      end
    end
  end

endmodule

// File: rtl/audio_serial_rx_chk.sv
module audio_serial_rx_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        valid,
  input logic        err,
  input logic [23:0] left,
  input logic [23:0] right,
  input logic [2:0]  fmt_act
);

  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    valid |=> !valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |-> ($stable(left) && $stable(right)));

  a_r7_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(err)) |-> (left == 24'd0 && right == 24'd0));

  a_r5_sext16: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(fmt_act) == 3'b010) |->
      (left[23:16] == {8{left[15]}} && right[23:16] == {8{right[15]}}));

  a_r5_sext20: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(fmt_act) == 3'b100) |->
      (left[23:20] == {4{left[19]}} && right[23:20] == {4{right[19]}}));

  a_r5_sext18: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && $past(fmt_act) == 3'b101) |->
      (left[23:18] == {6{left[17]}} && right[23:18] == {6{right[17]}}));

endmodule

bind audio_serial_rx audio_serial_rx_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .valid   (valid_o),
  .err     (fmt_err_o),
  .left    (left_o),
  .right   (right_o),
  .fmt_act (fmt_act)
);

// File: tb/audio_serial_rx_tb.sv
module audio_serial_rx_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sck = 1'b0, lrck = 1'b0, sdata = 1'b0;
  logic [2:0]  fmt = 3'b000;
  logic [23:0] left_o, right_o;
  logic        valid_o, fmt_err_o;

  int n_chk = 0, n_bad = 0, vcount = 0, dbl = 0;
  logic [23:0] last_l = '0, last_r = '0, prev_l = '0, prev_r = '0;
  logic        v_q = 1'b0;

  always #4 clk = ~clk;

  audio_serial_rx u_dut (
    .clk(clk), .rst_n(rst_n), .sck_i(sck), .lrck_i(lrck), .sdata_i(sdata),
    .fmt_i(fmt), .left_o(left_o), .right_o(right_o), .valid_o(valid_o),
    .fmt_err_o(fmt_err_o)
  );

  always @(negedge clk) begin
    if (valid_o) begin
      prev_l <= last_l; prev_r <= last_r;
      last_l <= left_o; last_r <= right_o;
      vcount <= vcount + 1;
      if (v_q) dbl <= dbl + 1;
    end
    v_q <= valid_o;
  end

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int width_of(input logic [2:0] f);
    case (f)
      3'b010: return 16;
      3'b011: return 24;
      3'b100: return 20;
      3'b101: return 18;
      default: return 24;
    endcase
  endfunction

  function automatic logic gen_bit(input logic [2:0] f, input logic [23:0] d,
                                   input int k, input int b);
    int n;
    case (f)
      3'b000: return (k < 24) ? d[23-k] : 1'b1;
      3'b001: return (k == 0 || k > 24) ? 1'b1 : d[24-k];
      3'b010, 3'b011, 3'b100, 3'b101: begin
        n = width_of(f);
        return (k < b - n) ? 1'b1 : d[n-1-(k-(b-n))];
      end
      default: return d[k % 24];
    endcase
  endfunction

  function automatic logic [23:0] exp_val(input logic [2:0] f, input logic [23:0] d,
                                          input int b);
    int n;
    logic [23:0] r;
    case (f)
      3'b000, 3'b001: begin
        n = (f == 3'b001) ? b - 1 : b;
        if (n >= 24) return d;
        r = d;
        for (int i = 0; i < 24 - n; i++) r[i] = 1'b0;
        return r;
      end
      3'b010, 3'b011, 3'b100, 3'b101: begin
        n = width_of(f);
        r = d;
        for (int i = n; i < 24; i++) r[i] = d[n-1];
        return r;
      end
      default: return 24'd0;
    endcase
  endfunction

  task automatic bit_out(input logic w, input logic d);
    @(negedge clk);
    lrck = w; sdata = d;
    repeat (3) @(negedge clk);
    sck = 1'b1;
    repeat (4) @(negedge clk);
    sck = 1'b0;
  endtask

  function automatic logic left_level(input logic [2:0] f);
    return (f == 3'b001) ? 1'b0 : 1'b1;
  endfunction

  task automatic send_half(input logic [2:0] f, input logic w, input logic [23:0] d,
                           input int b);
    for (int k = 0; k < b; k++) bit_out(w, gen_bit(f, d, k, b));
  endtask

  task automatic send_frame(input logic [2:0] f, input logic [23:0] l,
                            input logic [23:0] r, input int b);
    send_half(f, left_level(f), l, b);
    send_half(f, ~left_level(f), r, b);
  endtask

  task automatic tail(input logic [2:0] f);
    bit_out(left_level(f), 1'b0);
    repeat (12) @(negedge clk);
  endtask

  task automatic run_fmt(input string req, input logic [2:0] f, input int b,
                         input logic [23:0] l1, input logic [23:0] r1,
                         input logic [23:0] l2, input logic [23:0] r2);
    fmt = f;
    send_frame(f, 24'h5A5A5A, 24'hA5A5A5, b);
    send_frame(f, l1, r1, b);
    send_frame(f, l2, r2, b);
    tail(f);
    check({req, " first pair left"},   prev_l, exp_val(f, l1, b));
    check({req, " first pair right"},  prev_r, exp_val(f, r1, b));
    check({req, " second pair left"},  last_l, exp_val(f, l2, b));
    check({req, " second pair right"}, last_r, exp_val(f, r2, b));
  endtask

  task automatic t_reset;
    check("R1 left after reset",  left_o, 24'd0);
    check("R1 right after reset", right_o, 24'd0);
    check("R1 valid after reset", {23'd0, valid_o}, 24'd0);
    check("R1 err after reset",   {23'd0, fmt_err_o}, 24'd0);
  endtask

  task automatic t_hold;
    int v0;
    logic [23:0] l0, r0;
    v0 = vcount; l0 = left_o; r0 = right_o;
    repeat (200) @(negedge clk);
    check("R6 no strobe while idle", 24'(vcount - v0), 24'd0);
    check("R6 left held while idle", left_o, l0);
    check("R6 right held while idle", right_o, r0);
  endtask

  task automatic t_boundary;
    fmt = 3'b000;
    send_frame(3'b000, 24'h111111, 24'h222222, 32);
    send_half(3'b000, 1'b1, 24'hC0FFEE, 32);
    fmt = 3'b110;
    repeat (4) @(negedge clk);
    check("R8 err unchanged mid-frame", {23'd0, fmt_err_o}, 24'd0);
    send_half(3'b000, 1'b0, 24'h0BADF0, 32);
    send_frame(3'b110, 24'h7FFFFF, 24'h123456, 32);
    tail(3'b110);
    check("R8 frame before change left",  prev_l, 24'hC0FFEE);
    check("R8 frame before change right", prev_r, 24'h0BADF0);
    check("R7 reserved left zero",  last_l, 24'd0);
    check("R7 reserved right zero", last_r, 24'd0);
    check("R7 err raised",          {23'd0, fmt_err_o}, 24'd1);
  endtask

  task automatic t_reserved_111;
    run_fmt("R7 code 111", 3'b111, 32, 24'h00FF00, 24'hFFFFFF, 24'h800000, 24'h000001);
    check("R7 err for 111", {23'd0, fmt_err_o}, 24'd1);
  endtask

  task automatic t_recover;
    run_fmt("R8 return to left-justified", 3'b000, 32,
            24'h13579B, 24'h2468AC, 24'hFEDCBA, 24'h010203);
    check("R8 err cleared", {23'd0, fmt_err_o}, 24'd0);
  endtask

  initial begin
    #(8 * 150000);
    n_chk++; n_bad++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (6) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset;
    run_fmt("R2 left-justified 24 of 32", 3'b000, 32,
            24'h123456, 24'h89ABCD, 24'hFFFFFE, 24'h000001);
    run_fmt("R2 left-justified short half", 3'b000, 16,
            24'hABCDEF, 24'h7E5A3C, 24'h800001, 24'h00FFFF);
    run_fmt("R3 I2S", 3'b001, 32,
            24'hA1B2C3, 24'h0F0F0F, 24'h800000, 24'h7FFFFF);
    run_fmt("R4 R5 right-justified 16", 3'b010, 32,
            24'h008001, 24'h007FFF, 24'h00FFFF, 24'h001234);
    run_fmt("R4 right-justified 24", 3'b011, 32,
            24'h876543, 24'h345678, 24'hFFFFFF, 24'h000000);
    run_fmt("R4 R5 right-justified 20", 3'b100, 32,
            24'h080001, 24'h07FFFF, 24'h0ABCDE, 24'h012345);
    run_fmt("R4 R5 right-justified 18", 3'b101, 32,
            24'h020000, 24'h01FFFF, 24'h03ABCD, 24'h00F00F);
    t_hold;
    t_boundary;
    t_reserved_111;
    t_recover;
    check("R6 strobe one cycle wide", 24'(dbl), 24'd0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule